// File: doc/BRIEF.md
# Partial Reconfiguration Session Sequencer

This block drives the control handshake for one partial reconfiguration session against a configuration target. When it receives a start pulse, it first checks the target's mode-select strap and its two configuration pins. It then moves the target through a fixed bring-up: chip select is enabled, the clock/data path is enabled, and the overrides are enabled. A short flush burst is requested from an external clock-burst generator. The block then raises the reconfiguration request, requests a long preamble burst, and polls for the target's ready indication.

Once the target is ready, the block raises a data-ready output, and an external mover streams the image. When the mover signals end of data, the sequencer polls for the target's done indication. It then runs a fixed teardown and checks the target's final status pins. It reports the outcome as a two-bit code together with a one-cycle completion strobe.

Every poll is bounded and takes one cycle per attempt. An error flag seen while polling aborts the session. The teardown always runs once bring-up has started, whether or not the session succeeded.

Top module: `prSessionSeq`

## Requirements
- R1: A start pulse accepted in idle proceeds only when `modeSel` is 3'b000 or 3'b001. Any other value ends the session at once with status 2'b01 (invalid), and no control output leaves its idle value.
- R2: A start also fails with status 2'b01 unless both `nConfigPin` and `nStatusPin` are high. In that case no control output leaves its idle value.
- R3: `widthIs16` is high for the whole of an accepted session, including the cycle in which `chipSelN` falls. It is low again in the cycle in which `doneStrobe` is high.
- R4: Bring-up runs in strict order, with the first three steps one cycle apart:
  1. `chipSelN` low, while `prRequest` stays low.
  2. `clkDataEn` high.
  3. `overrideEn` high.
  4. A burst request of length 256.
  5. After that burst completes, `prRequest` high.
  6. A burst request of length 2047.
  7. After that burst completes, ready polling.
- R5: Ready polling samples `prError` and `prReady` once per cycle, for at most 10 attempts. `prError` takes priority and gives status 2'b01. Ready on attempts 1 to 10 succeeds. No ready by attempt 10 gives status 2'b10 (timeout). Both failures go on to teardown.
- R6: `dataReady` is high only after ready was seen and until the cycle after `dataEnd` is sampled. It never rises when ready polling failed.
- R7: Done polling starts after `dataEnd` and follows the same rules as R5, using `prDone`. Teardown runs whether done polling succeeded or failed.
- R8: Teardown runs in strict order:
  1. `prRequest` low.
  2. A burst request of length 256.
  3. After that burst completes, `clkDataEn` low.
  4. `chipSelN` high.
  5. `overrideEn` low.
  6. `doneStrobe`.
- R9: If no earlier error occurred, the session ends with status 2'b00 (ok) only when `userMode`, `confDone` and `nStatusPin` are all high after teardown. Otherwise it ends with status 2'b10. An earlier error code is kept.
- R10: Status codes are ok=2'b00, invalid=2'b01 and timeout=2'b10. Each session produces exactly one single-cycle `doneStrobe`. `status` holds its value until the next session ends.
- R11: A start pulse that arrives while a session is running is ignored. After the session's `doneStrobe`, no further session begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start pulse for a session |
| modeSel | input | 3 | Target mode-select strap |
| nConfigPin | input | 1 | Target configuration-reset pin level |
| nStatusPin | input | 1 | Target status pin level |
| userMode | input | 1 | Target reports user mode |
| confDone | input | 1 | Target configuration-done pin level |
| prReady | input | 1 | Target ready for reconfiguration data |
| prDone | input | 1 | Target reconfiguration complete |
| prError | input | 1 | Target reconfiguration error |
| burstDone | input | 1 | Burst generator finished the requested burst |
| dataEnd | input | 1 | Pulse from the data mover at end of image |
| chipSelN | output | 1 | Active-low chip select to the target |
| clkDataEn | output | 1 | Enables configuration clock and data path |
| overrideEn | output | 1 | Enables the control overrides |
| prRequest | output | 1 | Reconfiguration request to the target |
| widthIs16 | output | 1 | Selects the 16-bit configuration width |
| burstStart | output | 1 | One-cycle burst request |
| burstLen | output | 12 | Clock count of the requested burst |
| dataReady | output | 1 | Streaming window open |
| doneStrobe | output | 1 | One-cycle session completion |
| status | output | 2 | Session result code |

## Verification
The bench drives the ready and done indications at an exact poll attempt. This separates attempt 10, which must succeed, from attempt 11, which must time out. An off-by-one poll bound would flip one of those two results. It sends an error while ready is also pending, so a design that tested ready before error would report success. Failures in the done phase and in the final status check are paired with a check of the full teardown order, which catches a design that skips teardown on error or that releases the overrides before chip select. Starts with a bad strap or bad pin levels confirm that nothing toggles. A second start pulse in the middle of a session checks that no extra session follows.

// File: rtl/prSeqPkg.sv
package prSeqPkg;

  typedef enum logic [1:0] {
    ST_OK      = 2'b00,
    ST_INVALID = 2'b01,
    ST_TIMEOUT = 2'b10
  } seqStatus_e;

  typedef enum logic [4:0] {
    S_IDLE, S_CS_EN, S_PATH_EN, S_OVR_EN, S_FLUSH_REQ, S_FLUSH_WAIT,
    S_PR_REQ, S_PRE_REQ, S_PRE_WAIT, S_POLL_RDY, S_STREAM, S_POLL_DONE,
    S_TD_DROP, S_TD_FLUSH_REQ, S_TD_FLUSH_WAIT, S_TD_PATH_OFF,
    S_TD_CS_OFF, S_TD_OVR_OFF, S_FINAL, S_REPORT
  } seqState_e;

  typedef struct packed {
    logic setCs;
    logic clrCs;
    logic setPath;
    logic clrPath;
    logic setOvr;
    logic clrOvr;
    logic setReq;
    logic clrReq;
    logic burstGo;
    logic burstLong;
    logic setStream;
    logic clrStream;
    logic pollClr;
    logic pollInc;
    logic report;
  } seqStrobe_t;

endpackage

// File: rtl/prSeqCtrl.sv
module prSeqCtrl
  import prSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic [2:0] modeSel,
  input  logic       nConfigPin,
  input  logic       nStatusPin,
  input  logic       userMode,
  input  logic       confDone,
  input  logic       prReady,
  input  logic       prDone,
  input  logic       prError,
  input  logic       burstDone,
  input  logic       dataEnd,
  input  logic       pollLast,
  output seqStrobe_t strb,
  output seqStatus_e finalCode
);

  seqState_e  state, nextState;
  seqStatus_e errQ, errD;

  logic startBad;
  assign startBad = (modeSel[2:1] != 2'b00) || !nConfigPin || !nStatusPin;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      errQ  <= ST_OK;
    end else begin
      state <= nextState;
      errQ  <= errD;
    end
  end

  always_comb begin
    strb      = '0;
    nextState = state;
    errD      = errQ;
    unique case (state)
      S_IDLE: if (startReq) begin
        if (startBad) begin
          errD      = ST_INVALID;
          nextState = S_REPORT;
        end else begin
          errD      = ST_OK;
          nextState = S_CS_EN;
        end
      end
      S_CS_EN:     begin strb.setCs   = 1'b1; nextState = S_PATH_EN;   end
      S_PATH_EN:   begin strb.setPath = 1'b1; nextState = S_OVR_EN;    end
      S_OVR_EN:    begin strb.setOvr  = 1'b1; nextState = S_FLUSH_REQ; end
      S_FLUSH_REQ: begin strb.burstGo = 1'b1; nextState = S_FLUSH_WAIT; end
      S_FLUSH_WAIT: if (burstDone) nextState = S_PR_REQ;
      S_PR_REQ:    begin strb.setReq  = 1'b1; nextState = S_PRE_REQ;   end
      S_PRE_REQ: begin
        strb.burstGo   = 1'b1;
        strb.burstLong = 1'b1;
        nextState      = S_PRE_WAIT;
      end
      S_PRE_WAIT: if (burstDone) begin
        strb.pollClr = 1'b1;
        nextState    = S_POLL_RDY;
      end
      S_POLL_RDY: begin
        if (prError) begin
          errD      = ST_INVALID;
          nextState = S_TD_DROP;
        end else if (prReady) begin
          strb.setStream = 1'b1;
          nextState      = S_STREAM;
        end else if (pollLast) begin
          errD      = ST_TIMEOUT;
          nextState = S_TD_DROP;
        end else begin
          strb.pollInc = 1'b1;
        end
      end
      S_STREAM: if (dataEnd) begin
        strb.clrStream = 1'b1;
        strb.pollClr   = 1'b1;
        nextState      = S_POLL_DONE;
      end
      S_POLL_DONE: begin
        if (prError) begin
          errD      = ST_INVALID;
          nextState = S_TD_DROP;
        end else if (prDone) begin
          nextState = S_TD_DROP;
        end else if (pollLast) begin
          errD      = ST_TIMEOUT;
          nextState = S_TD_DROP;
        end else begin
          strb.pollInc = 1'b1;
        end
      end
      S_TD_DROP:       begin strb.clrReq  = 1'b1; nextState = S_TD_FLUSH_REQ; end
      S_TD_FLUSH_REQ:  begin strb.burstGo = 1'b1; nextState = S_TD_FLUSH_WAIT; end
      S_TD_FLUSH_WAIT: if (burstDone) nextState = S_TD_PATH_OFF;
      S_TD_PATH_OFF:   begin strb.clrPath = 1'b1; nextState = S_TD_CS_OFF;  end
      S_TD_CS_OFF:     begin strb.clrCs   = 1'b1; nextState = S_TD_OVR_OFF; end
      S_TD_OVR_OFF:    begin strb.clrOvr  = 1'b1; nextState = S_FINAL;      end
      S_FINAL: begin
        if (errQ == ST_OK && !(userMode && confDone && nStatusPin))
          errD = ST_TIMEOUT;
        nextState = S_REPORT;
      end
      S_REPORT: begin
        strb.report = 1'b1;
        nextState   = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign finalCode = errQ;

  // R5: a reconfiguration error during ready polling never opens streaming
  a_r5_error_blocks_stream: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_POLL_RDY && prError) |=> (state != S_STREAM));

  // R1: a bad strap at start goes straight to reporting
  a_r1_bad_mode_reports: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && startReq && modeSel[2:1] != 2'b00) |=> (state == S_REPORT && errQ == ST_INVALID));

  // R11: a start pulse while busy does not restart bring-up
  a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_STREAM && startReq && !dataEnd) |=> (state == S_STREAM));

endmodule

// File: rtl/prSeqDatapath.sv
module prSeqDatapath
  import prSeqPkg::*;
#(
  parameter int POLL_MAX      = 10,
  parameter int BURST_W       = 12,
  parameter int FLUSH_CLKS    = 256,
  parameter int PREAMBLE_CLKS = 2047
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobe_t         strb,
  input  seqStatus_e         finalCode,
  output logic               chipSelN,
  output logic               clkDataEn,
  output logic               overrideEn,
  output logic               prRequest,
  output logic               widthIs16,
  output logic               burstStart,
  output logic [BURST_W-1:0] burstLen,
  output logic               dataReady,
  output logic               doneStrobe,
  output logic [1:0]         status,
  output logic               pollLast
);

  localparam int POLL_W = $clog2(POLL_MAX + 1);
  localparam logic [BURST_W-1:0] FLUSH_LEN = BURST_W'(FLUSH_CLKS);
  localparam logic [BURST_W-1:0] PRE_LEN   = BURST_W'(PREAMBLE_CLKS);
  localparam logic [POLL_W-1:0]  POLL_END  = POLL_W'(POLL_MAX - 1);

  logic [POLL_W-1:0] pollCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chipSelN   <= 1'b1;
      clkDataEn  <= 1'b0;
      overrideEn <= 1'b0;
      prRequest  <= 1'b0;
      widthIs16  <= 1'b0;
      burstStart <= 1'b0;
      burstLen   <= '0;
      dataReady  <= 1'b0;
      doneStrobe <= 1'b0;
      status     <= ST_OK;
      pollCnt    <= '0;
    end else begin
      burstStart <= strb.burstGo;
      doneStrobe <= strb.report;
      if (strb.burstGo)  burstLen <= strb.burstLong ? PRE_LEN : FLUSH_LEN;
      if (strb.report)   status   <= finalCode;
      if (strb.setCs) begin
        chipSelN  <= 1'b0;
        widthIs16 <= 1'b1;
      end
      if (strb.clrCs)     chipSelN   <= 1'b1;
      if (strb.report)    widthIs16  <= 1'b0;
      if (strb.setPath)   clkDataEn  <= 1'b1;
      if (strb.clrPath)   clkDataEn  <= 1'b0;
      if (strb.setOvr)    overrideEn <= 1'b1;
      if (strb.clrOvr)    overrideEn <= 1'b0;
      if (strb.setReq)    prRequest  <= 1'b1;
      if (strb.clrReq)    prRequest  <= 1'b0;
      if (strb.setStream) dataReady  <= 1'b1;
      if (strb.clrStream) dataReady  <= 1'b0;
      if (strb.pollClr)       pollCnt <= '0;
      else if (strb.pollInc)  pollCnt <= pollCnt + 1'b1;
    end
  end

  assign pollLast = (pollCnt == POLL_END);

  // R4: clock/data path comes up with chip select already low, before overrides and request
  a_r4_path_after_cs: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clkDataEn) |-> (!chipSelN && !prRequest && !overrideEn));

  // R4: the request is raised only with the path, overrides and chip select all active
  a_r4_req_after_ovr: assert property (@(posedge clk) disable iff (!rstN)
    $rose(prRequest) |-> (overrideEn && clkDataEn && !chipSelN));

  // R8: overrides are released last
  a_r8_ovr_off_last: assert property (@(posedge clk) disable iff (!rstN)
    $fell(overrideEn) |-> (chipSelN && !clkDataEn && !prRequest));

  // R6: streaming only while the request is held
  a_r6_stream_under_req: assert property (@(posedge clk) disable iff (!rstN)
    dataReady |-> prRequest);

  // R10: completion strobe lasts one cycle
  a_r10_strobe_single: assert property (@(posedge clk) disable iff (!rstN)
    doneStrobe |=> !doneStrobe);

  // R3: narrow width whenever chip select is active
  a_r3_width_in_session: assert property (@(posedge clk) disable iff (!rstN)
    !chipSelN |-> widthIs16);

endmodule

// File: rtl/prSessionSeq.sv
module prSessionSeq
  import prSeqPkg::*;
#(
  parameter int POLL_MAX      = 10,
  parameter int BURST_W       = 12,
  parameter int FLUSH_CLKS    = 256,
  parameter int PREAMBLE_CLKS = 2047
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startReq,
  input  logic [2:0]         modeSel,
  input  logic               nConfigPin,
  input  logic               nStatusPin,
  input  logic               userMode,
  input  logic               confDone,
  input  logic               prReady,
  input  logic               prDone,
  input  logic               prError,
  input  logic               burstDone,
  input  logic               dataEnd,
  output logic               chipSelN,
  output logic               clkDataEn,
  output logic               overrideEn,
  output logic               prRequest,
  output logic               widthIs16,
  output logic               burstStart,
  output logic [BURST_W-1:0] burstLen,
  output logic               dataReady,
  output logic               doneStrobe,
  output logic [1:0]         status
);

  seqStrobe_t strb;
  seqStatus_e finalCode;
  logic       pollLast;

  prSeqCtrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .startReq   (startReq),
    .modeSel    (modeSel),
    .nConfigPin (nConfigPin),
    .nStatusPin (nStatusPin),
    .userMode   (userMode),
    .confDone   (confDone),
    .prReady    (prReady),
    .prDone     (prDone),
    .prError    (prError),
    .burstDone  (burstDone),
    .dataEnd    (dataEnd),
    .pollLast   (pollLast),
    .strb       (strb),
    .finalCode  (finalCode)
  );

  prSeqDatapath #(
    .POLL_MAX      (POLL_MAX),
    .BURST_W       (BURST_W),
    .FLUSH_CLKS    (FLUSH_CLKS),
    .PREAMBLE_CLKS (PREAMBLE_CLKS)
  ) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .finalCode  (finalCode),
    .chipSelN   (chipSelN),
    .clkDataEn  (clkDataEn),
    .overrideEn (overrideEn),
    .prRequest  (prRequest),
    .widthIs16  (widthIs16),
    .burstStart (burstStart),
    .burstLen   (burstLen),
    .dataReady  (dataReady),
    .doneStrobe (doneStrobe),
    .status     (status),
    .pollLast   (pollLast)
  );

endmodule

// File: tb/tb_prSessionSeq.sv
`timescale 1ns/1ps
module tb_prSessionSeq;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic [2:0] modeSel = 3'b000;
  logic nConfigPin = 1'b1, nStatusPin = 1'b1, userMode = 1'b1, confDone = 1'b1;
  logic prReady = 1'b0, prDone = 1'b0, prError = 1'b0, burstDone = 1'b0, dataEnd = 1'b0;
  logic chipSelN, clkDataEn, overrideEn, prRequest, widthIs16, burstStart;
  logic [11:0] burstLen;
  logic dataReady, doneStrobe;
  logic [1:0] status;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  prSessionSeq dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .modeSel(modeSel),
    .nConfigPin(nConfigPin), .nStatusPin(nStatusPin), .userMode(userMode),
    .confDone(confDone), .prReady(prReady), .prDone(prDone), .prError(prError),
    .burstDone(burstDone), .dataEnd(dataEnd), .chipSelN(chipSelN),
    .clkDataEn(clkDataEn), .overrideEn(overrideEn), .prRequest(prRequest),
    .widthIs16(widthIs16), .burstStart(burstStart), .burstLen(burstLen),
    .dataReady(dataReady), .doneStrobe(doneStrobe), .status(status)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int expStatus(int mode, int nc, int ns, int rdyAt, int re,
                                   int doneAt, int de, int fo);
    if (mode > 1 || nc == 0 || ns == 0) return 1;
    if (re != 0) return 1;
    if (rdyAt < 1 || rdyAt > 10) return 2;
    if (de != 0) return 1;
    if (doneAt < 1 || doneAt > 10) return 2;
    if (fo == 0) return 2;
    return 0;
  endfunction

  task automatic runSession(input int mode, input int nc, input int ns,
                            input int rdyAt, input int re, input int doneAt,
                            input int de, input int fo, input int ms);
    int ev[13];
    int cyc = 0, burstNum = 0, burstWait = -1, rdyN = -1, doneN = -1, streamCnt = 0;
    bit endSent = 0, seenDone = 0, badStream = 0, widthAtDone = 1, idleBad = 0;
    int gotSt = -1, exp;
    logic pCs = 1, pPath = 0, pOvr = 0, pReq = 0, pRdy = 0;
    foreach (ev[k]) ev[k] = -1;
    modeSel = mode[2:0]; nConfigPin = nc[0]; nStatusPin = ns[0];
    userMode = fo[0]; confDone = 1'b1;
    prReady = 0; prDone = 0; prError = re[0]; burstDone = 0; dataEnd = 0;
    @(negedge clk) startReq = 1'b1;
    for (int i = 0; i < 300 && !seenDone; i++) begin
      @(negedge clk);
      cyc++;
      // observe
      if (pCs && !chipSelN) ev[0] = cyc;
      if (!pPath && clkDataEn) ev[1] = cyc;
      if (!pOvr && overrideEn) ev[2] = cyc;
      if (!pReq && prRequest) ev[4] = cyc;
      if (!pRdy && dataReady) ev[6] = cyc;
      if (pReq && !prRequest) ev[7] = cyc;
      if (pPath && !clkDataEn) ev[9] = cyc;
      if (!pCs && chipSelN) ev[10] = cyc;
      if (pOvr && !overrideEn) ev[11] = cyc;
      if (dataReady && (!prReady || endSent)) badStream = 1;
      if (burstStart) begin
        burstNum++;
        if (burstNum == 1) begin
          ev[3] = cyc;
          check(burstLen == 12'd256, "R4", "flush burst length", burstLen, 256);
          check(widthIs16 == 1'b1, "R3", "width during session", widthIs16, 1);
        end else if (burstNum == 2) begin
          ev[5] = cyc;
          check(burstLen == 12'd2047, "R4", "preamble burst length", burstLen, 2047);
        end else begin
          ev[8] = cyc;
          check(burstLen == 12'd256, "R8", "teardown burst length", burstLen, 256);
        end
      end
      if (doneStrobe) begin
        ev[12] = cyc; seenDone = 1; gotSt = status; widthAtDone = widthIs16;
      end
      pCs = chipSelN; pPath = clkDataEn; pOvr = overrideEn; pReq = prRequest; pRdy = dataReady;
      // respond
      startReq = 1'b0;
      if (burstDone) begin
        burstDone = 0;
        if (burstNum == 2) rdyN = 0;
      end
      if (burstWait > 0) burstWait--;
      else if (burstWait == 0) begin burstDone = 1; burstWait = -1; end
      if (burstStart) burstWait = 2;
      if (rdyN >= 0) begin
        if (rdyN == rdyAt - 1) prReady = 1;
        rdyN++;
      end
      if (dataEnd) begin dataEnd = 0; doneN = 0; end
      if (dataReady && !endSent) begin
        streamCnt++;
        if (ms != 0 && streamCnt == 2) startReq = 1'b1;
        if (streamCnt == 4) begin
          dataEnd = 1; endSent = 1;
          if (de != 0) prError = 1;
        end
      end
      if (doneN >= 0) begin
        if (doneN == doneAt - 1) prDone = 1;
        doneN++;
      end
    end
    startReq = 1'b0;
    exp = expStatus(mode, nc, ns, rdyAt, re, doneAt, de, fo);
    check(seenDone, "R10", "session completed", seenDone, 1);
    check(gotSt == exp, (exp == 0) ? "R9" : (re != 0 || rdyAt < 1 || rdyAt > 10) ? "R5" : "R7",
          "status code", gotSt, exp);
    if (mode > 1 || nc == 0 || ns == 0) begin
      bit quiet = 1;
      for (int k = 0; k < 12; k++) if (ev[k] != -1) quiet = 0;
      check(quiet, (mode > 1) ? "R1" : "R2", "outputs idle after rejected start", quiet, 1);
    end else begin
      check(ev[0] >= 0 && ev[1] == ev[0] + 1 && ev[2] == ev[1] + 1 && ev[3] == ev[2] + 1
            && ev[4] > ev[3] && ev[5] > ev[4], "R4", "bring-up order", ev[4], ev[3] + 1);
      check(ev[7] > ev[5] && ev[8] > ev[7] && ev[9] > ev[8] && ev[10] > ev[9]
            && ev[11] > ev[10] && ev[12] > ev[11], "R8", "teardown order", ev[11], ev[10] + 1);
      if (re == 0 && rdyAt >= 1 && rdyAt <= 10)
        check(ev[6] > ev[5] && ev[6] < ev[7] && !badStream, "R6", "stream window", ev[6], ev[5] + 1);
      else
        check(ev[6] == -1, "R6", "no stream after failed ready", ev[6], -1);
      check(widthAtDone == 1'b0, "R3", "width released at done", widthAtDone, 0);
    end
    repeat (8) begin
      @(negedge clk);
      if (!chipSelN || doneStrobe) idleBad = 1;
    end
    check(!idleBad, "R11", "idle after session", idleBad, 0);
    check(status == 2'(exp), "R10", "status held", status, exp);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    repeat (4) @(negedge clk);
    check(chipSelN == 1 && clkDataEn == 0 && overrideEn == 0 && prRequest == 0,
          "R10", "reset controls", {chipSelN, clkDataEn, overrideEn, prRequest}, 8);
    check(doneStrobe == 0 && status == 2'b00 && widthIs16 == 0 && dataReady == 0 && burstStart == 0,
          "R10", "reset status", {doneStrobe, status}, 0);
    rstN = 1'b1;
    @(negedge clk);
    runSession(0, 1, 1, 1, 0, 1, 0, 1, 0);   // nominal (R4 R6 R8 R9)
    runSession(1, 1, 1, 10, 0, 10, 0, 1, 0); // poll bound edge (R5 R7)
    runSession(2, 1, 1, 1, 0, 1, 0, 1, 0);   // R1
    runSession(7, 1, 1, 1, 0, 1, 0, 1, 0);   // R1
    runSession(0, 0, 1, 1, 0, 1, 0, 1, 0);   // R2
    runSession(0, 1, 0, 1, 0, 1, 0, 1, 0);   // R2
    runSession(0, 1, 1, 11, 0, 1, 0, 1, 0);  // R5 timeout
    runSession(0, 1, 1, 0, 0, 1, 0, 1, 0);   // R5 never ready
    runSession(0, 1, 1, 3, 1, 1, 0, 1, 0);   // R5 error priority
    runSession(1, 1, 1, 2, 0, 11, 0, 1, 0);  // R7 timeout with teardown
    runSession(0, 1, 1, 2, 0, 1, 1, 1, 0);   // R7 error with teardown
    runSession(0, 1, 1, 2, 0, 2, 0, 0, 0);   // R9 final check fails
    runSession(0, 1, 1, 1, 0, 1, 0, 1, 1);   // R11 start while busy
    for (int n = 0; n < 24; n++) begin
      int m  = ($urandom % 4 == 0) ? int'($urandom % 8) : int'($urandom % 2);
      int nc = ($urandom % 8 == 0) ? 0 : 1;
      int ns = ($urandom % 8 == 0) ? 0 : 1;
      int ra = int'($urandom % 12) + 1;
      int re = ($urandom % 8 == 0) ? 1 : 0;
      int da = int'($urandom % 12) + 1;
      int de = ($urandom % 8 == 0) ? 1 : 0;
      int fo = ($urandom % 6 == 0) ? 0 : 1;
      int ms = int'($urandom % 2);
      runSession(m, nc, ns, ra, re, da, de, fo, ms);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule